// File: doc/BRIEF.md
# Sum-Addressed Word-Line Decoder

This block selects one word line of a memory array from an address that arrives as two parts, a base and an offset. The address is never added first and then decoded. Each word line has its own comparator. The comparator checks whether its own fixed row number could be the sum of the two operands.

For each bit, a row can work out two carries from the operand bits and its own row bit. The first is the carry that must enter that bit for the row bit to be right. The second is the carry that bit would pass upward. The row fires only when these carries agree at every boundary. Because no carry travels across the word, each row costs a shallow AND of per-bit agreement terms.

The block has no clock and no state. An enable input forces every word line low.

Top module: `sum_addr_wl_decoder`

## Requirements
- R1: With `en` high, exactly one bit of `wl` is 1. Its index is `(base_op + offset_op) mod 2^N`, with bit r of `wl` being word line r.
- R2: With `en` low, every bit of `wl` is 0, whatever the operands.
- R3: When `base_op + offset_op` reaches or exceeds 2^N, the carry out of the top bit is dropped. For example, all-ones plus 1 selects word line 0, and the selected line then has an index below `base_op`.
- R4: With `offset_op` zero and `en` high, the selected line is the one whose index equals `base_op`.
- R5: Swapping `base_op` and `offset_op` selects the same word line.
- R6: Row r matches only when, for every bit i, the carry required into bit i equals the carry generated out of bit i-1, with a carry of 0 assumed into bit 0. The required carry is `base_op[i] ^ offset_op[i] ^ r[i]`. The generated carry is `(base_op[i] & offset_op[i]) | ((base_op[i] ^ offset_op[i]) & ~r[i])`.
- R7: The outputs follow an operand change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | High to drive a word line; low forces all lines to 0 |
| base_op | input | N | Base part of the address |
| offset_op | input | N | Offset part of the address |
| wl | output | 2^N | One-hot word-line select, bit r is row r |

## Verification
The bench builds the decoder twice, once at N=4 and once at N=8. At N=4 every one of the 256 operand pairs is checked against a one-hot decode of the true sum, so every row and every carry pattern is covered. At N=8 there are 65,536 pairs, too many to sweep, so a random sample is checked instead, together with directed wrap, zero-offset, swap and disable cases. This exercises comparators whose carry agreement has to hold across a longer run of bits.

// File: rtl/sum_addr_wl_decoder.sv
module sum_addr_wl_decoder #(
  parameter int N = 4
) (
  input  logic              en,
  input  logic [N-1:0]      base_op,
  input  logic [N-1:0]      offset_op,
  output logic [(1<<N)-1:0] wl
);
  localparam int ROWS = 1 << N;

  logic [N-1:0] p;
  logic [N-2:0] g;

  assign p = base_op ^ offset_op;
  assign g = base_op[N-2:0] & offset_op[N-2:0];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int unsigned KR = r;
    logic [N-1:0] agree;

    for (genvar i = 0; i < N; i++) begin : g_bit
      logic req;
      assign req = KR[i] ? ~p[i] : p[i];
      if (i == 0) begin : g_lsb
        assign agree[i] = ~req;
      end else begin : g_upper
        logic gen_prev;
        assign gen_prev = KR[i-1] ? g[i-1] : (g[i-1] | p[i-1]);
        assign agree[i] = ~(req ^ gen_prev);
      end
    end

    assign wl[r] = en & (&agree);
  end

  always_comb begin
    if (en) begin
      p_onehot_r1: assert ($onehot(wl))
        else $error("R1: not one-hot");
      p_index_r6: assert (wl[N'(base_op + offset_op)])
        else $error("R6: wrong row matched");
      if (offset_op == '0) begin
        p_zero_offset_r4: assert (wl[base_op])
          else $error("R4: zero offset row");
      end
      if ({1'b0, base_op} + {1'b0, offset_op} >= (N+1)'(ROWS)) begin
        p_wrap_r3: assert ((wl >> base_op) == '0)
          else $error("R3: wrap row not below base");
      end
    end else begin
      p_idle_r2: assert (wl == '0)
        else $error("R2: line high while disabled");
    end
  end
endmodule

// File: tb/tb_sum_addr_wl_decoder.sv
module tb_sum_addr_wl_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;

  logic       en4, en8;
  logic [3:0] a4, b4;
  logic [7:0] a8, b8;
  logic [15:0]  wl4;
  logic [255:0] wl8;

  sum_addr_wl_decoder #(.N(4)) dut (
    .en(en4), .base_op(a4), .offset_op(b4), .wl(wl4));
  sum_addr_wl_decoder #(.N(8)) dut_w8 (
    .en(en8), .base_op(a8), .offset_op(b8), .wl(wl8));

  function automatic logic [15:0] exp4(input logic e, input logic [3:0] a, input logic [3:0] b);
    logic [3:0] s;
    s = a + b;
    return e ? (16'(1) << s) : '0;
  endfunction

  function automatic logic [255:0] exp8(input logic e, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] s;
    s = a + b;
    return e ? (256'(1) << s) : '0;
  endfunction

  task automatic chk4(input string req, input logic [15:0] exp);
    checks++;
    if (wl4 !== exp) begin
      failures++;
      $display("FAIL %s n4 a=%0d b=%0d en=%0b actual=%h expected=%h", req, a4, b4, en4, wl4, exp);
    end
  endtask

  task automatic chk8(input string req, input logic [255:0] exp);
    checks++;
    if (wl8 !== exp) begin
      failures++;
      $display("FAIL %s n8 a=%0d b=%0d en=%0b actual=%h expected=%h", req, a8, b8, en8, wl8, exp);
    end
  endtask

  task automatic drive(input logic e4, input logic [3:0] x4, input logic [3:0] y4,
                       input logic e8, input logic [7:0] x8, input logic [7:0] y8);
    @(posedge clk);
    en4 = e4; a4 = x4; b4 = y4;
    en8 = e8; a8 = x8; b8 = y8;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    drive(1'b0, 4'd0, 4'd0, 1'b0, 8'd0, 8'd0);
    chk4("R2", '0);
    chk8("R2", '0);
  endtask

  task automatic t_exhaustive4;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        drive(1'b1, 4'(a), 4'(b), 1'b0, 8'd0, 8'd0);
        chk4("R1_R6", exp4(1'b1, 4'(a), 4'(b)));
      end
  endtask

  task automatic t_random8;
    for (int k = 0; k < 1500; k++) begin
      logic [7:0] x, y;
      x = 8'($urandom);
      y = 8'($urandom);
      drive(1'b1, 4'd0, 4'd0, 1'b1, x, y);
      chk8("R1_R6", exp8(1'b1, x, y));
    end
  endtask

  task automatic t_disable;
    drive(1'b0, 4'd7, 4'd9, 1'b0, 8'd200, 8'd100);
    chk4("R2", '0);
    chk8("R2", '0);
    drive(1'b0, 4'd15, 4'd15, 1'b0, 8'd255, 8'd255);
    chk4("R2", '0);
    chk8("R2", '0);
  endtask

  task automatic t_wrap;
    drive(1'b1, 4'd15, 4'd1, 1'b1, 8'd255, 8'd1);
    chk4("R3", 16'h0001);
    chk8("R3", 256'(1));
    drive(1'b1, 4'd12, 4'd9, 1'b1, 8'd200, 8'd100);
    chk4("R3", 16'(1) << 5);
    chk8("R3", 256'(1) << 44);
  endtask

  task automatic t_zero_offset;
    drive(1'b1, 4'd11, 4'd0, 1'b1, 8'd173, 8'd0);
    chk4("R4", 16'(1) << 11);
    chk8("R4", 256'(1) << 173);
  endtask

  task automatic t_swap;
    logic [255:0] first;
    drive(1'b1, 4'd3, 4'd14, 1'b1, 8'd37, 8'd250);
    first = wl8;
    chk4("R5", exp4(1'b1, 4'd14, 4'd3));
    drive(1'b1, 4'd14, 4'd3, 1'b1, 8'd250, 8'd37);
    chk4("R5", exp4(1'b1, 4'd3, 4'd14));
    chk8("R5", first);
  endtask

  task automatic t_no_clock;
    @(negedge clk);
    en8 = 1'b1; a8 = 8'd90; b8 = 8'd10;
    #1;
    chk8("R7", 256'(1) << 100);
    b8 = 8'd11;
    #1;
    chk8("R7", 256'(1) << 101);
  endtask

  initial begin
    en4 = 1'b0; a4 = '0; b4 = '0;
    en8 = 1'b0; a8 = '0; b8 = '0;
    t_reset_state();
    t_exhaustive4();
    t_random8();
    t_disable();
    t_wrap();
    t_zero_offset();
    t_swap();
    t_no_clock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule